// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Controller

This block keeps one 32-bit control/status word per DMA channel and gives each bit of that word its own write behaviour. Sticky status flags record events coming from the channel engines and the request router, and software clears them by writing ones. Control bits are stored as written. Two strobe bits set or clear a compare flag and are never stored themselves. A write that starts a channel sends a command to that channel's engine. If descriptor fetching is enabled, a descriptor-load command goes out first and the run command follows one cycle later.

Each channel's status word produces one interrupt bit. Start and end events always count. Stopped, end-of-receive and request-asserted count only when their enable bits are set. The per-channel interrupt bits form a read-only summary word, and a single interrupt output is the OR of that word. Register access is a simple word port: writes take effect at the clock edge, and read data is registered and appears one cycle after the read strobe. Channel words sit at addresses 0 to NUM_CH-1 and the summary word at address NUM_CH.

Top module: `dcs_ctrl`

## Requirements
- R1: After reset every channel word reads 0x0000_0008 (only the stopped bit, bit 3, set), the summary reads 0, and irq_o, run_o and fetch_o are all low.
- R2: Writing 1 to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that bit. Writing 0 to it leaves it unchanged.
- R3: Bits 31, 30, 29, 28, 27, 26 and 23 (run, no-fetch, stop-irq enable, EOR-irq enable, EOR jump enable, EOR stop enable, request-irq enable) take the written value. Bits 25, 24, 22 and all unnamed bits always read 0.
- R4: A write with bit 24 set clears the compare bit (bit 10), and a write with bit 25 set sets it. When both are set, bit 10 ends up set.
- R5: A write with bit 31 set clears the stopped bit and the request-asserted bit (bit 4). With bit 30 clear, fetch_o for that channel pulses in the cycle after the write and run_o pulses in the following cycle. With bit 30 set, only run_o pulses, in the cycle after the write.
- R6: A write with bits 31 and 22 both 0 sets the stopped bit. A write with bit 31 = 0 and bit 22 = 1 leaves the stopped bit unchanged.
- R7: One-cycle event pulses set the status bits as follows: ev_buserr sets bit 0, ev_start bit 1, ev_end bit 2, ev_stop bit 3, ev_ras bit 4 and ev_eor bit 9.
- R8: When an event pulse and a write that would clear the same bit fall in the same cycle, the bit ends up set.
- R9: A channel's interrupt is active when any of these holds: start is set; end is set; stopped and bit 29 are both set; EOR and bit 28 are both set; request-asserted and bit 23 are both set. Bus error never raises an interrupt.
- R10: Summary bit i follows channel i's interrupt, and irq_o is the OR of the summary bits. Both update one cycle after the status change.
- R11: The summary word at address NUM_CH is read-only, and writes to it change nothing. Reads at addresses above NUM_CH return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | AW | Word address: channel index, or NUM_CH for the summary |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd_en |
| ev_buserr | input | NUM_CH | Bus error event pulse per channel |
| ev_start | input | NUM_CH | Descriptor start event pulse per channel |
| ev_end | input | NUM_CH | Transfer end event pulse per channel |
| ev_stop | input | NUM_CH | Channel stopped event pulse |
| ev_ras | input | NUM_CH | Request asserted event pulse |
| ev_eor | input | NUM_CH | End-of-receive event pulse |
| fetch_o | output | NUM_CH | Descriptor-load command pulse per channel |
| run_o | output | NUM_CH | Run command pulse per channel |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
A corrupted status bit in a channel word shows up in the next read of that word, one cycle after the read strobe. When the bit is an interrupt source, irq_o and the summary word also change one cycle after the bad bit is stored. A wrong write semantic, such as a stored strobe bit, a clear that beats an event, or a missed stopped set, therefore appears in the read-back right after the offending write. A wrong command ordering appears at fetch_o and run_o within the two cycles that follow the run write.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int REG_W = 32;

  // status bit positions (decoded by software and by the interrupt logic)
  localparam int B_BERR  = 0;
  localparam int B_START = 1;
  localparam int B_END   = 2;
  localparam int B_STOP  = 3;
  localparam int B_RAS   = 4;
  localparam int B_EOR   = 9;
  localparam int B_CMP   = 10;
  // control / strobe positions
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_EORSTOP = 26;
  localparam int B_EORJMP  = 27;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;

  localparam logic [REG_W-1:0] RESET_WORD = REG_W'(1) << B_STOP;

  typedef struct packed {
    logic berr;
    logic start;
    logic fin;
    logic stop;
    logic ras;
    logic eor;
  } chan_ev_t;

  function automatic logic chan_irq(input logic [REG_W-1:0] s);
    return s[B_START] | s[B_END]
         | (s[B_STOP] & s[B_STOPEN])
         | (s[B_EOR]  & s[B_EOREN])
         | (s[B_RAS]  & s[B_RASEN]);
  endfunction
endpackage

// File: rtl/dcs_chan_reg.sv
module dcs_chan_reg
  import dcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  chan_ev_t         ev,
  output logic [REG_W-1:0] status_o,
  output logic             go_o,
  output logic             nofetch_o
);
  logic [REG_W-1:0] st_q, st_d;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[21:11], wdata[8:5]};

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      // plain control bits
      st_d[31:26]   = wdata[31:26];
      st_d[B_RASEN] = wdata[B_RASEN];
      // write-one-to-clear sticky flags
      st_d[B_BERR]  = st_q[B_BERR]  & ~wdata[B_BERR];
      st_d[B_START] = st_q[B_START] & ~wdata[B_START];
      st_d[B_END]   = st_q[B_END]   & ~wdata[B_END];
      st_d[B_EOR]   = st_q[B_EOR]   & ~wdata[B_EOR];
      // compare flag strobes, set has priority
      if (wdata[B_CMPCLR]) st_d[B_CMP] = 1'b0;
      if (wdata[B_CMPSET]) st_d[B_CMP] = 1'b1;
      // run / stop handling
      if (wdata[B_RUN]) begin
        st_d[B_STOP] = 1'b0;
        st_d[B_RAS]  = 1'b0;
      end else if (!wdata[B_MASKRUN]) begin
        st_d[B_STOP] = 1'b1;
      end
    end
    // events override any clear in the same cycle
    if (ev.berr)  st_d[B_BERR]  = 1'b1;
    if (ev.start) st_d[B_START] = 1'b1;
    if (ev.fin)   st_d[B_END]   = 1'b1;
    if (ev.stop)  st_d[B_STOP]  = 1'b1;
    if (ev.ras)   st_d[B_RAS]   = 1'b1;
    if (ev.eor)   st_d[B_EOR]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= RESET_WORD;
    else     st_q <= st_d;
  end

  assign status_o  = st_q;
  assign go_o      = wr_en & wdata[B_RUN];
  assign nofetch_o = wdata[B_NOFETCH];

  // R2
  start_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[B_START] && !ev.start) |=> !status_o[B_START]);
  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> status_o[B_START]);
  // R4
  cmp_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[B_CMPSET]) |=> status_o[B_CMP]);
  // R4
  cmp_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[B_CMPCLR] && !wdata[B_CMPSET]) |=> !status_o[B_CMP]);
  // R3
  strobe_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[B_CMPCLR] == 1'b0 && status_o[B_CMPSET] == 1'b0 && status_o[B_MASKRUN] == 1'b0);
  // R6
  stop_on_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdata[B_RUN] && !wdata[B_MASKRUN]) |=> status_o[B_STOP]);
endmodule

// File: rtl/dcs_cmd_seq.sv
module dcs_cmd_seq (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic nofetch,
  output logic fetch_o,
  output logic run_o
);
  logic fetch_q, run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      fetch_q <= go & ~nofetch;
      run_q   <= (go & nofetch) | fetch_q;
    end
  end

  assign fetch_o = fetch_q;
  assign run_o   = run_q;

  // R5
  fetch_then_run_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_o |=> run_o);
  // R5
  direct_run_chk: assert property (@(posedge clk) disable iff (rst)
    (go && nofetch) |=> (run_o && !fetch_o));
endmodule

// File: rtl/dcs_irq_sum.sv
module dcs_irq_sum #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_int,
  output logic [NUM_CH-1:0] sum_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] sum_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= chan_int;
      irq_q <= |chan_int;
    end
  end

  assign sum_o = sum_q;
  assign irq_o = irq_q;

  // R10
  irq_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (sum_o != '0));
  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|chan_int));
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] ev_buserr,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_stop,
  input  logic [NUM_CH-1:0] ev_ras,
  input  logic [NUM_CH-1:0] ev_eor,
  output logic [NUM_CH-1:0] fetch_o,
  output logic [NUM_CH-1:0] run_o,
  output logic              irq_o
);
  localparam logic [AW-1:0] SUM_ADDR = AW'(NUM_CH);

  logic [REG_W-1:0]  stat [NUM_CH];
  logic [NUM_CH-1:0] chan_int;
  logic [NUM_CH-1:0] sum;
  logic [REG_W-1:0]  rdata_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic     sel, go, nofetch;
    chan_ev_t ev;

    assign sel = reg_wr_en && (reg_addr == AW'(i));
    assign ev  = '{berr: ev_buserr[i], start: ev_start[i], fin: ev_end[i],
                   stop: ev_stop[i], ras: ev_ras[i], eor: ev_eor[i]};

    dcs_chan_reg u_reg (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (sel),
      .wdata     (reg_wdata),
      .ev        (ev),
      .status_o  (stat[i]),
      .go_o      (go),
      .nofetch_o (nofetch)
    );

    dcs_cmd_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .go      (go),
      .nofetch (nofetch),
      .fetch_o (fetch_o[i]),
      .run_o   (run_o[i])
    );

    assign chan_int[i] = chan_irq(stat[i]);
  end

  dcs_irq_sum #(.NUM_CH(NUM_CH)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .chan_int (chan_int),
    .sum_o    (sum),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      rdata_q <= '0;
      for (int i = 0; i < NUM_CH; i++)
        if (reg_addr == AW'(i)) rdata_q <= stat[i];
      if (reg_addr == SUM_ADDR) rdata_q <= REG_W'(sum);
    end
  end

  assign reg_rdata = rdata_q;

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr > SUM_ADDR) |=> (reg_rdata == '0));
  // R10
  sum_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == SUM_ADDR) |=> (reg_rdata == REG_W'($past(sum))));
endmodule

// File: tb/dcs_ctrl_tb_top.sv
module dcs_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int AW  = $clog2(NCH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  ev_buserr = '0, ev_start = '0, ev_end = '0;
  logic [NCH-1:0]  ev_stop = '0, ev_ras = '0, ev_eor = '0;
  logic [NCH-1:0]  fetch_o, run_o;
  logic            irq_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  dcs_ctrl #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_buserr(ev_buserr), .ev_start(ev_start), .ev_end(ev_end),
    .ev_stop(ev_stop), .ev_ras(ev_ras), .ev_eor(ev_eor),
    .fetch_o(fetch_o), .run_o(run_o), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // set one event bit; kind 0 berr,1 start,2 end,3 stop,4 ras,5 eor
  task automatic set_ev(input int kind, input int ch, input logic v);
    case (kind)
      0: ev_buserr[ch] = v;
      1: ev_start[ch]  = v;
      2: ev_end[ch]    = v;
      3: ev_stop[ch]   = v;
      4: ev_ras[ch]    = v;
      default: ev_eor[ch] = v;
    endcase
  endtask

  // write, optionally with an event in the same cycle (kind < 0: none)
  task automatic wr_ev(input int addr, input logic [31:0] d, input int kind, input int ch);
    reg_wr_en = 1'b1; reg_addr = AW'(addr); reg_wdata = d;
    if (kind >= 0) set_ev(kind, ch, 1'b1);
    tick();
    reg_wr_en = 1'b0;
    if (kind >= 0) set_ev(kind, ch, 1'b0);
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    wr_ev(addr, d, -1, 0);
  endtask

  task automatic pulse(input int kind, input int ch);
    set_ev(kind, ch, 1'b1);
    tick();
    set_ev(kind, ch, 1'b0);
  endtask

  // driver: push expected read value, issue read
  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    reg_rd_en = 1'b1; reg_addr = AW'(addr);
    tick();
    reg_rd_en = 1'b0;
  endtask

  // monitor: compare registered read data against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd_en) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: unexpected read data 0x%08h expected none", reg_rdata);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(reg_rdata, e.val, e.tag);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;

    // R1 reset state
    for (int c = 0; c < NCH; c++) rd(c, 32'h0000_0008, "R1 channel reset word");
    tick();
    rd(NCH, 32'h0, "R1 summary after reset");
    check({31'd0, irq_o}, 32'd0, "R1 irq after reset");
    check({28'd0, run_o}, 32'd0, "R1 run after reset");
    check({28'd0, fetch_o}, 32'd0, "R1 fetch after reset");

    // R3 / R4 control bits and compare strobes on channel 2
    wr(2, 32'h5F80_0000);
    rd(2, 32'h5C80_0408, "R3 control stored, R4 both strobes set");
    wr(2, 32'h5D80_0000);
    rd(2, 32'h5C80_0008, "R4 compare cleared by bit 24");
    wr(2, 32'h5E80_0000);
    rd(2, 32'h5C80_0408, "R4 compare set by bit 25");

    // R5 run with descriptor fetch on channel 1
    wr(1, 32'h8000_0000);
    check({28'd0, fetch_o}, 32'h2, "R5 fetch pulse first");
    check({28'd0, run_o}, 32'h0, "R5 no run with fetch");
    tick();
    check({28'd0, run_o}, 32'h2, "R5 run after fetch");
    check({28'd0, fetch_o}, 32'h0, "R5 fetch single pulse");
    rd(1, 32'h8000_0000, "R5 stopped cleared by run");
    // R6 mask-run keeps stopped, plain halt sets it
    wr(1, 32'h0040_0000);
    rd(1, 32'h0000_0000, "R6 mask-run leaves stopped");
    wr(1, 32'h0000_0000);
    rd(1, 32'h0000_0008, "R6 halt sets stopped");

    // R5 run without descriptor fetch on channel 3
    wr(3, 32'hC000_0000);
    check({28'd0, run_o}, 32'h8, "R5 direct run");
    check({28'd0, fetch_o}, 32'h0, "R5 no fetch when disabled");
    rd(3, 32'hC000_0000, "R5 no-fetch run word");

    // R7 / R9 bus error sets bit 0, no interrupt
    pulse(0, 0);
    rd(0, 32'h0000_0009, "R7 bus error bit");
    tick();
    check({31'd0, irq_o}, 32'd0, "R9 bus error raises no irq");

    // R7 / R10 start event, irq timing
    pulse(1, 0);
    check({31'd0, irq_o}, 32'd0, "R10 irq not yet");
    tick();
    check({31'd0, irq_o}, 32'd1, "R10 irq one cycle after status");
    rd(NCH, 32'h1, "R10 summary bit 0");
    // R2 clear start and bus error
    wr(0, 32'h0000_0003);
    rd(0, 32'h0000_0008, "R2 W1C bits 0 and 1");
    tick();
    check({31'd0, irq_o}, 32'd0, "R2 irq gone after clear");

    // end and EOR
    pulse(2, 0);
    tick();
    check({31'd0, irq_o}, 32'd1, "R9 end unconditional");
    pulse(5, 0);
    rd(0, 32'h0000_020C, "R7 end and eor bits");
    wr(0, 32'h0000_0004);
    rd(0, 32'h0000_0208, "R2 end cleared, eor kept");
    tick();
    check({31'd0, irq_o}, 32'd0, "R9 eor gated off");
    wr(0, 32'h1000_0000);
    tick();
    check({31'd0, irq_o}, 32'd1, "R9 eor enabled");
    wr(0, 32'h1000_0200);
    rd(0, 32'h1000_0008, "R2 eor cleared");
    tick();
    check({31'd0, irq_o}, 32'd0, "R9 irq off after eor clear");

    // stopped gating
    wr(0, 32'h2000_0000);
    tick();
    check({31'd0, irq_o}, 32'd1, "R9 stopped with enable");
    wr(0, 32'h0000_0000);
    tick();
    check({31'd0, irq_o}, 32'd0, "R9 stopped without enable");

    // request-asserted
    pulse(4, 0);
    rd(0, 32'h0000_0018, "R7 request-asserted bit");
    tick();
    check({31'd0, irq_o}, 32'd0, "R9 ras gated off");
    wr(0, 32'h0080_0000);
    tick();
    check({31'd0, irq_o}, 32'd1, "R9 ras enabled");
    rd(0, 32'h0080_0018, "R3 ras enable stored");
    wr(0, 32'h8000_0000);
    rd(0, 32'h8000_0000, "R5 run clears stopped and ras");
    tick();
    check({31'd0, irq_o}, 32'd0, "R5 irq off after run");
    wr(0, 32'h0000_0000);
    rd(0, 32'h0000_0008, "R6 channel 0 halted");

    // R8 event beats clear in same cycle
    wr_ev(1, 32'h0000_0002, 1, 1);
    rd(1, 32'h0000_000A, "R8 start event beats W1C");
    wr_ev(1, 32'h8000_0002, 3, 1);
    rd(1, 32'h8000_0008, "R8 stop event beats run clear");
    wr(1, 32'h0000_0000);
    rd(1, 32'h0000_0008, "R6 channel 1 halted");

    // R10 summary with two channels
    pulse(1, 2);
    pulse(1, 3);
    tick();
    rd(NCH, 32'h0000_000C, "R10 summary channels 2 and 3");
    check({31'd0, irq_o}, 32'd1, "R10 irq from two channels");

    // R11 summary read-only, unmapped address
    wr(NCH, 32'hFFFF_FFFF);
    tick();
    rd(NCH, 32'h0000_000C, "R11 summary write ignored");
    rd(NCH + 1, 32'h0, "R11 unmapped reads zero");
    rd(0, 32'h0000_0008, "R11 summary write did not alias");
    wr(2, 32'h0000_0002);
    wr(3, 32'h0000_0002);
    tick();
    tick();
    check({31'd0, irq_o}, 32'd0, "R10 irq cleared");
    rd(NCH, 32'h0, "R10 summary cleared");

    repeat (3) tick();
    finish_run();
  end
endmodule